// File: doc/BRIEF.md
# Always-On Real-Time Counter with Power-Off Request

This block is a small register-mapped peripheral for the always-on part of a chip. It holds a 47-bit counter. The counter advances once for each cycle in which a 32.768 kHz tick-enable input is high. Software sees the counter as a 15-bit upper word and a 32-bit lower word. Software can read either word. Writing a word replaces only that half of the counter.

The block also holds a 32-bit control word that software can read back in full. A control write that has two particular bits both set produces a single-cycle power-off request. The system power controller uses that request to shut the chip down.

The register bus is minimal. It has an address, a write strobe and write data. Read data depends only on the current address and the stored state, so it is valid in the same cycle as the address.

Top module: `lp_rtc_regs`

## Requirements
- R1: After reset, the counter is zero, the control word is zero and `pwr_off_req` is low.
- R2: In a cycle with `tick_en` high and no counter write, the counter increases by one at the clock edge. It wraps from 2^47-1 to 0. Without a tick, the counter holds its value.
- R3: Reading offset 0x050 returns counter bits 46:32 in `bus_rdata[14:0]`, with bits 31:15 zero. Reading offset 0x054 returns counter bits 31:0. Read data follows the address in the same cycle.
- R4: A write to offset 0x054 loads counter bits 31:0 from the write data. Counter bits 46:32 keep their value.
- R5: A write to offset 0x050 loads counter bits 46:32 from `bus_wdata[14:0]`. Write data bits 31:15 are discarded, and counter bits 31:0 keep their value.
- R6: When a counter write and a tick occur in the same cycle, the write wins and that tick is lost. Counting resumes from the written value on the next tick.
- R7: A write to offset 0x038 stores all 32 bits of write data in the control word. A read of offset 0x038 returns the stored control word unchanged.
- R8: `pwr_off_req` is high for exactly the one cycle after a control write in which write data bits 6 and 5 are both 1. A control write with only one of those bits set produces no pulse, and the stored bits do not keep the request high.
- R9: Reads at any other offset return zero. Writes at any other offset change neither the counter nor the control word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle strobe at 32.768 kHz that advances the counter |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle |
| pwr_off_req | output | 1 | One-cycle system power-off request |

## Verification
A wrong counter state shows up as a mismatch the next time the bench reads either counter word. Because the bench compares read data in every cycle, the error appears one cycle after the edge that caused it. A carry that fails to reach the upper half shows up only when the lower word wraps, so the bench deliberately loads values just below the 32-bit and 47-bit boundaries. A control register or power-off decode fault shows on `bus_rdata` or `pwr_off_req` in the cycle after the control write. The bench also writes values with only one of the two trigger bits set, and keeps the trigger pattern stored over idle cycles, so that a pulse is not confused with a level.

// File: rtl/lp_rtc_regs.sv
module lp_rtc_regs #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 47,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h038,
  parameter logic [ADDR_W-1:0] HI_OFS   = 12'h050,
  parameter logic [ADDR_W-1:0] LO_OFS   = 12'h054,
  parameter int OFF_BIT_A = 6,
  parameter int OFF_BIT_B = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwr_off_req
);
  localparam int HI_W = CNT_W - DATA_W;
  localparam logic [CNT_W-1:0] ONE = 1;

  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] ctrl;

  wire wr_ctrl = bus_we && (bus_addr == CTRL_OFS);
  wire wr_hi   = bus_we && (bus_addr == HI_OFS);
  wire wr_lo   = bus_we && (bus_addr == LO_OFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (wr_hi)   cnt <= {bus_wdata[HI_W-1:0], cnt[DATA_W-1:0]};
    else if (wr_lo)   cnt <= {cnt[CNT_W-1:DATA_W], bus_wdata};
    else if (tick_en) cnt <= cnt + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl        <= '0;
      pwr_off_req <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= bus_wdata;
      pwr_off_req <= wr_ctrl && bus_wdata[OFF_BIT_A] && bus_wdata[OFF_BIT_B];
    end
  end

  always_comb begin
    if (bus_addr == HI_OFS)        bus_rdata = {{(DATA_W-HI_W){1'b0}}, cnt[CNT_W-1:DATA_W]};
    else if (bus_addr == LO_OFS)   bus_rdata = cnt[DATA_W-1:0];
    else if (bus_addr == CTRL_OFS) bus_rdata = ctrl;
    else                           bus_rdata = '0;
  end

  p_tick_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wr_hi && !wr_lo) |=> cnt == $past(cnt) + ONE);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_hi && !wr_lo) |=> $stable(cnt));
  p_lo_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (cnt[DATA_W-1:0] == $past(bus_wdata)) && $stable(cnt[CNT_W-1:DATA_W]));
  p_hi_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (cnt[CNT_W-1:DATA_W] == $past(bus_wdata[HI_W-1:0])) && $stable(cnt[DATA_W-1:0]));
  p_ctrl_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl));
  p_pwr_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off_req |-> $past(wr_ctrl && bus_wdata[OFF_BIT_A] && bus_wdata[OFF_BIT_B]));
  p_hi_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == HI_OFS) |-> bus_rdata[DATA_W-1:HI_W] == '0);
endmodule

// File: tb/lp_rtc_regs_tb.sv
module lp_rtc_regs_tb_top;
  localparam int CLK_PER = 10;
  localparam longint CMASK = (64'sd1 <<< 47) - 1;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic pwr_off_req;

  int checks = 0, fails = 0;
  bit done = 0;

  longint m_cnt;
  logic [31:0] m_ctrl;
  bit m_pwr;

  always #(CLK_PER/2) clk = ~clk;

  lp_rtc_regs dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwr_off_req(pwr_off_req));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ctrl = 0; m_pwr = 0;
    end else begin
      m_pwr = 0;
      if (bus_we && bus_addr == 12'h050)
        m_cnt = (longint'(bus_wdata & 32'h7FFF) <<< 32) | (m_cnt & 64'hFFFF_FFFF);
      else if (bus_we && bus_addr == 12'h054)
        m_cnt = (m_cnt & ~64'hFFFF_FFFF) | longint'(bus_wdata);
      else if (tick_en)
        m_cnt = (m_cnt + 1) & CMASK;
      if (bus_we && bus_addr == 12'h038) begin
        m_ctrl = bus_wdata;
        m_pwr = bus_wdata[6] && bus_wdata[5];
      end
    end
  end

  function automatic logic [31:0] exp_rd(logic [11:0] a);
    if (a == 12'h050) return 32'(m_cnt >>> 32);
    if (a == 12'h054) return 32'(m_cnt);
    if (a == 12'h038) return m_ctrl;
    return 32'h0;
  endfunction

  task automatic step(logic [11:0] a, logic we, logic [31:0] d, logic tk, string tag);
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wdata = d; tick_en = tk;
    #1;
    checks++;
    if (bus_rdata !== exp_rd(a)) begin
      fails++;
      $display("FAIL %s rdata addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp_rd(a));
    end
    checks++;
    if (pwr_off_req !== m_pwr) begin
      fails++;
      $display("FAIL %s pwr_off_req actual=%b expected=%b", tag, pwr_off_req, m_pwr);
    end
  endtask

  initial begin
    #(CLK_PER*200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(12'h050, 0, 0, 0, "R1");
    step(12'h054, 0, 0, 0, "R1");
    step(12'h038, 0, 0, 0, "R1");
    for (int i = 0; i < 20; i++) step(12'h054, 0, 0, i[0], "R2");
    step(12'h054, 1, 32'hFFFF_FFFE, 0, "R4");
    for (int i = 0; i < 4; i++) step(12'h050, 0, 0, 1, "R3");
    step(12'h054, 0, 0, 0, "R3");
    step(12'h050, 1, 32'h0000_7FFF, 0, "R5");
    step(12'h054, 1, 32'hFFFF_FFFF, 0, "R4");
    step(12'h050, 0, 0, 1, "R2");
    step(12'h050, 0, 0, 0, "R2");
    step(12'h054, 0, 0, 0, "R2");
    step(12'h050, 1, 32'hFFFF_8001, 0, "R5");
    step(12'h050, 0, 0, 0, "R5");
    step(12'h054, 1, 32'h1234_5678, 1, "R6");
    step(12'h054, 0, 0, 1, "R6");
    step(12'h050, 1, 32'h0000_0abc, 1, "R6");
    step(12'h050, 0, 0, 0, "R6");
    step(12'h038, 1, 32'h0000_0020, 0, "R8");
    step(12'h038, 1, 32'h0000_0040, 0, "R8");
    step(12'h038, 1, 32'h0000_0060, 0, "R8");
    step(12'h038, 0, 0, 0, "R8");
    step(12'h038, 0, 0, 0, "R8");
    step(12'h038, 1, 32'hDEAD_BEEF, 0, "R7");
    step(12'h038, 1, 32'hDEAD_BEEF, 0, "R8");
    step(12'h038, 0, 0, 0, "R7");
    step(12'h04C, 1, 32'hFFFF_FFFF, 0, "R9");
    step(12'h058, 1, 32'hFFFF_FFFF, 0, "R9");
    step(12'h000, 1, 32'h1111_1111, 0, "R9");
    step(12'h051, 0, 0, 0, "R9");
    step(12'h038, 0, 0, 0, "R9");
    step(12'h054, 0, 0, 0, "R9");
    step(12'h050, 0, 0, 0, "R9");
    lf = 32'hACE1_2345;
    for (int i = 0; i < 300; i++) begin
      logic [11:0] a;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      case (lf[3:1])
        3'd0, 3'd1: a = 12'h054;
        3'd2, 3'd3: a = 12'h050;
        3'd4, 3'd5: a = 12'h038;
        default:    a = {lf[15:8], 4'h0};
      endcase
      step(a, lf[20] & lf[9], {lf[7:0], lf[31:8]}, lf[4], "R2");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule